// File: doc/BRIEF.md
# Test Access Port with Bypass and User Data Register

This block is a single-device serial test access port. A 16-state controller, clocked on the rising edge of the test clock, follows the mode-select input. The controller selects which shift path sits between the serial data input and the serial data output. The paths are a 3-bit instruction register, a 1-bit bypass register and an 8-bit user data register. Each path has a shift stage and a held output. The held output changes only in the matching update state.

The user register loads a parallel capture word when a data scan begins. It shifts that word out least significant bit first while the new word shifts in. The new word appears on a parallel update output when the scan ends. Any instruction other than the user code routes the data scan through the bypass bit.

Top module: `tap_port`

## Requirements
- R1: From any state, five or more consecutive rising test-clock edges with mode-select high leave the controller in Test-Logic-Reset. In that state the serial-output valid flag is low.
- R2: From Test-Logic-Reset, the mode-select sequence 0,1,1,0,0 reaches Shift-IR. The first three shifted-out bits are then 1,0,0, which is the fixed capture pattern 3'b001 sent LSB first.
- R3: The instruction register is 3 bits wide. Serial data enters at the MSB end and leaves from the LSB end. The held instruction changes only in Update-IR (or on reset). Code 3'b010 selects the user register, and every other code, including 3'b110, selects bypass.
- R4: With bypass selected, Capture-DR clears the single bypass bit. Serial output then repeats serial input delayed by one shift, and the parallel update output is unaffected.
- R5: With the user register selected, Capture-DR loads the parallel capture input. The captured word leaves on serial output LSB first while the new word shifts in.
- R6: From the last Shift-DR bit (mode-select 1), the mode-select sequence 1,0 passes through Update-DR and returns to Run-Test/Idle. The update output takes the shifted word there, and at no other time.
- R7: Test-Logic-Reset forces the held instruction to the bypass code 3'b110. It leaves the update output unchanged.
- R8: Serial output changes on the falling test-clock edge. The valid flag is high only in Shift-IR or Shift-DR, and serial output is 0 while the flag is low.
- R9: Pause-DR holds the partially shifted word. Resuming through Exit2-DR continues the same scan.
- R10: A synchronous active-high reset puts the controller in Test-Logic-Reset. It sets the instruction to 3'b110, clears the update output and lowers the valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| cap_in | input | 8 | Parallel word captured by the user register |
| tdo | output | 1 | Serial data out, changes on falling tck |
| tdo_en | output | 1 | High while tdo carries shifted data |
| upd_out | output | 8 | Parallel output of the user register |

## Verification
The bench builds the port with its default sizes: a 3-bit instruction and an 8-bit user register. With these sizes a full user scan is short enough to pause midway and still check every captured bit against the serial output. The same sizes make the 3'b001 capture pattern, the bypass code and the user code three distinct values, so a mis-decoded instruction shows up as the wrong scan length or the wrong serial data. Unknown codes, reset through the mode-select line and reset through the reset pin are each followed by a bypass scan to show which instruction is held.

// File: rtl/tap_pkg.sv
package tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_SEL_DR,
        ST_CAP_DR,
        ST_SHF_DR,
        ST_EX1_DR,
        ST_PAU_DR,
        ST_EX2_DR,
        ST_UPD_DR,
        ST_SEL_IR,
        ST_CAP_IR,
        ST_SHF_IR,
        ST_EX1_IR,
        ST_PAU_IR,
        ST_EX2_IR,
        ST_UPD_IR
    } tap_state_e;

    // One-hot-ish strobes decoded from the controller state
    typedef struct packed {
        logic in_reset;
        logic cap_ir;
        logic shf_ir;
        logic upd_ir;
        logic cap_dr;
        logic shf_dr;
        logic upd_dr;
    } tap_ctl_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        tap_state_e n;
        case (s)
            ST_RESET:  n = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   n = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: n = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: n = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: n = tms ? ST_SEL_DR : ST_IDLE;
            default:   n = ST_RESET;
        endcase
        return n;
    endfunction

    function automatic tap_ctl_t tap_decode(input tap_state_e s);
        tap_ctl_t c;
        c.in_reset = (s == ST_RESET);
        c.cap_ir   = (s == ST_CAP_IR);
        c.shf_ir   = (s == ST_SHF_IR);
        c.upd_ir   = (s == ST_UPD_IR);
        c.cap_dr   = (s == ST_CAP_DR);
        c.shf_dr   = (s == ST_SHF_DR);
        c.upd_dr   = (s == ST_UPD_DR);
        return c;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state,
    output tap_ctl_t   ctl
);

    always_ff @(posedge tck) begin
        if (rst) state <= ST_RESET;
        else     state <= tap_next(state, tms);
    end

    assign ctl = tap_decode(state);

    // Run of consecutive high mode-select samples, used only by the check below
    logic [2:0] ones_run;
    always_ff @(posedge tck) begin
        if (rst)      ones_run <= '0;
        else if (tms) ones_run <= (ones_run == 3'd7) ? 3'd7 : ones_run + 3'd1;
        else          ones_run <= '0;
    end

    p_tms_reset_r1: assert property (@(posedge tck) disable iff (rst)
        (ones_run >= 3'd5) |-> (state == ST_RESET));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
#(
    parameter int              IR_W     = 3,
    parameter logic [IR_W-1:0] RST_CODE = 3'b110,
    parameter logic [IR_W-1:0] CAP_CODE = 3'b001
) (
    input  logic            tck,
    input  logic            rst,
    input  tap_ctl_t        ctl,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_lsb
);

    logic [IR_W-1:0] ir_sr;

    always_ff @(posedge tck) begin
        if (rst)             ir_sr <= CAP_CODE;
        else if (ctl.cap_ir) ir_sr <= CAP_CODE;
        else if (ctl.shf_ir) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    always_ff @(posedge tck) begin
        if (rst)               ir_q <= RST_CODE;
        else if (ctl.in_reset) ir_q <= RST_CODE;
        else if (ctl.upd_ir)   ir_q <= ir_sr;
    end

    assign ir_lsb = ir_sr[0];

    logic unused_ctl;
    assign unused_ctl = ^{ctl.cap_dr, ctl.shf_dr, ctl.upd_dr};

    p_ir_cap_r2: assert property (@(posedge tck) disable iff (rst)
        ctl.cap_ir |=> (ir_sr == CAP_CODE));

    p_ir_hold_r3: assert property (@(posedge tck) disable iff (rst)
        !(ctl.in_reset || ctl.upd_ir) |=> $stable(ir_q));

    p_ir_force_r7: assert property (@(posedge tck) disable iff (rst)
        ctl.in_reset |=> (ir_q == RST_CODE));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int              IR_W     = 3,
    parameter int              DR_W     = 8,
    parameter logic [IR_W-1:0] USR_CODE = 3'b010
) (
    input  logic            tck,
    input  logic            rst,
    input  tap_ctl_t        ctl,
    input  logic            tdi,
    input  logic [IR_W-1:0] ir_q,
    input  logic [DR_W-1:0] cap_in,
    output logic [DR_W-1:0] upd_out,
    output logic            dr_lsb
);

    logic            sel_user;
    logic            byp_q;
    logic [DR_W-1:0] usr_sr;

    assign sel_user = (ir_q == USR_CODE);

    always_ff @(posedge tck) begin
        if (rst)                          byp_q <= 1'b0;
        else if (ctl.cap_dr && !sel_user) byp_q <= 1'b0;
        else if (ctl.shf_dr && !sel_user) byp_q <= tdi;
    end

    always_ff @(posedge tck) begin
        if (rst)                         usr_sr <= '0;
        else if (ctl.cap_dr && sel_user) usr_sr <= cap_in;
        else if (ctl.shf_dr && sel_user) usr_sr <= {tdi, usr_sr[DR_W-1:1]};
    end

    always_ff @(posedge tck) begin
        if (rst)                         upd_out <= '0;
        else if (ctl.upd_dr && sel_user) upd_out <= usr_sr;
    end

    assign dr_lsb = sel_user ? usr_sr[0] : byp_q;

    logic unused_ctl;
    assign unused_ctl = ^{ctl.in_reset, ctl.cap_ir, ctl.shf_ir, ctl.upd_ir};

    p_byp_cap_r4: assert property (@(posedge tck) disable iff (rst)
        (ctl.cap_dr && !sel_user) |=> (byp_q == 1'b0));

    p_usr_cap_r5: assert property (@(posedge tck) disable iff (rst)
        (ctl.cap_dr && sel_user) |=> (usr_sr == $past(cap_in)));

    p_upd_hold_r6: assert property (@(posedge tck) disable iff (rst)
        !(ctl.upd_dr && sel_user) |=> $stable(upd_out));

endmodule

// File: rtl/tap_port.sv
module tap_port
    import tap_pkg::*;
#(
    parameter int              IR_W     = 3,
    parameter int              DR_W     = 8,
    parameter logic [IR_W-1:0] BYP_CODE = 3'b110,
    parameter logic [IR_W-1:0] USR_CODE = 3'b010,
    parameter logic [IR_W-1:0] CAP_CODE = 3'b001
) (
    input  logic            tck,
    input  logic            trst,
    input  logic            tms,
    input  logic            tdi,
    input  logic [DR_W-1:0] cap_in,
    output logic            tdo,
    output logic            tdo_en,
    output logic [DR_W-1:0] upd_out
);

    tap_state_e      state;
    tap_ctl_t        ctl;
    logic [IR_W-1:0] ir_q;
    logic            ir_lsb;
    logic            dr_lsb;

    tap_fsm u_fsm (
        .tck   (tck),
        .rst   (trst),
        .tms   (tms),
        .state (state),
        .ctl   (ctl)
    );

    tap_ir #(
        .IR_W     (IR_W),
        .RST_CODE (BYP_CODE),
        .CAP_CODE (CAP_CODE)
    ) u_ir (
        .tck    (tck),
        .rst    (trst),
        .ctl    (ctl),
        .tdi    (tdi),
        .ir_q   (ir_q),
        .ir_lsb (ir_lsb)
    );

    tap_dr #(
        .IR_W     (IR_W),
        .DR_W     (DR_W),
        .USR_CODE (USR_CODE)
    ) u_dr (
        .tck     (tck),
        .rst     (trst),
        .ctl     (ctl),
        .tdi     (tdi),
        .ir_q    (ir_q),
        .cap_in  (cap_in),
        .upd_out (upd_out),
        .dr_lsb  (dr_lsb)
    );

    // Serial output launched half a cycle after the state change
    always_ff @(negedge tck) begin
        if (trst) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= ctl.shf_ir | ctl.shf_dr;
            tdo    <= ctl.shf_ir ? ir_lsb : (ctl.shf_dr ? dr_lsb : 1'b0);
        end
    end

    p_tdo_en_r8: assert property (@(posedge tck) disable iff (trst)
        tdo_en == ((state == ST_SHF_IR) || (state == ST_SHF_DR)));

    p_tdo_quiet_r8: assert property (@(posedge tck) disable iff (trst)
        !tdo_en |-> !tdo);

endmodule

// File: tb/tb_tap_port.sv
`timescale 1ns/1ps
module tb_tap_port;

    localparam int IR_W = 3;
    localparam int DR_W = 8;

    logic            tck = 1'b0;
    logic            trst = 1'b1;
    logic            tms = 1'b1;
    logic            tdi = 1'b0;
    logic [DR_W-1:0] cap_in = '0;
    logic            tdo;
    logic            tdo_en;
    logic [DR_W-1:0] upd_out;

    always #4 tck = ~tck;

    tap_port #(.IR_W(IR_W), .DR_W(DR_W)) dut (
        .tck     (tck),
        .trst    (trst),
        .tms     (tms),
        .tdi     (tdi),
        .cap_in  (cap_in),
        .tdo     (tdo),
        .tdo_en  (tdo_en),
        .upd_out (upd_out)
    );

    typedef struct {
        logic  e_tdo;
        logic  e_en;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    // Monitor: compares the serial output late in each cycle
    initial begin
        forever begin
            exp_t it;
            @(negedge tck);
            #3;
            if (sbq.size() > 0) begin
                it = sbq.pop_front();
                checks++;
                if (tdo_en !== it.e_en || (it.e_en && tdo !== it.e_tdo)) begin
                    errors++;
                    $display("FAIL %s: tdo_en=%b tdo=%b expected tdo_en=%b tdo=%b",
                             it.tag, tdo_en, tdo, it.e_en, it.e_tdo);
                end
            end
        end
    end

    task automatic check_val(input string tag, input logic [DR_W-1:0] act,
                             input logic [DR_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one test-clock cycle, optional expected serial item
    task automatic tick(input logic m, input logic d, input bit chk,
                        input logic e_tdo, input logic e_en, input string tag);
        @(posedge tck);
        #2;
        tms = m;
        tdi = d;
        if (chk) sbq.push_back('{e_tdo, e_en, tag});
    endtask

    task automatic shift_ir(input logic [IR_W-1:0] code);
        tick(1, 0, 1, 0, 0, "R8 idle");
        tick(1, 0, 0, 0, 0, "");
        tick(0, 0, 0, 0, 0, "");
        tick(0, 0, 0, 0, 0, "");
        for (int i = 0; i < IR_W; i++)
            tick(i == IR_W - 1, code[i], 1, (i == 0), 1, "R2 ir capture");
        tick(1, 0, 1, 0, 0, "R8 exit1-ir");
        tick(0, 0, 0, 0, 0, "");
    endtask

    task automatic shift_dr(input int n, input logic [15:0] din,
                            input logic [15:0] dexp, input string tag);
        tick(1, 0, 1, 0, 0, "R8 idle");
        tick(0, 0, 0, 0, 0, "");
        tick(0, 0, 1, 0, 0, "R8 capture-dr");
        for (int i = 0; i < n; i++)
            tick(i == n - 1, din[i], 1, dexp[i], 1, tag);
        tick(1, 0, 1, 0, 0, "R8 exit1-dr");
        tick(0, 0, 0, 0, 0, "");
    endtask

    initial begin
        logic [15:0] pat;

        repeat (3) @(posedge tck);
        #2;
        trst = 1'b0;
        check_val("R10 reset update output", upd_out, 8'h00);
        check_val("R10 reset valid flag", {7'd0, tdo_en}, 8'h00);

        // R4 / R10: instruction after reset is bypass
        tick(0, 0, 0, 0, 0, "");
        pat = 16'h00B2;
        shift_dr(8, pat, {pat[14:0], 1'b0}, "R4 bypass");
        tick(0, 0, 0, 0, 0, "");
        check_val("R4 bypass keeps update output", upd_out, 8'h00);

        // R2 / R3: load user code
        shift_ir(3'b010);
        tick(0, 0, 0, 0, 0, "");

        // R5 / R6: capture A5, write F5
        cap_in = 8'hA5;
        shift_dr(8, 16'h00F5, 16'h00A5, "R5 user capture");
        tick(0, 0, 0, 0, 0, "");
        check_val("R6 update output", upd_out, 8'hF5);

        // R9 / R6: scan paused midway
        cap_in = 8'h3C;
        pat = 16'h0081;
        tick(1, 0, 1, 0, 0, "R8 idle");
        tick(0, 0, 0, 0, 0, "");
        tick(0, 0, 0, 0, 0, "");
        for (int i = 0; i < 3; i++)
            tick(i == 2, pat[i], 1, cap_in[i], 1, "R9 before pause");
        tick(0, 0, 1, 0, 0, "R8 exit1-dr");
        tick(0, 0, 1, 0, 0, "R9 pause");
        check_val("R6 stable while paused", upd_out, 8'hF5);
        tick(1, 0, 1, 0, 0, "R9 pause");
        tick(0, 0, 1, 0, 0, "R9 exit2-dr");
        for (int i = 3; i < 8; i++)
            tick(i == 7, pat[i], 1, cap_in[i], 1, "R9 after pause");
        tick(1, 0, 0, 0, 0, "");
        tick(0, 0, 0, 0, 0, "");
        tick(0, 0, 0, 0, 0, "");
        check_val("R9 paused scan result", upd_out, 8'h81);

        // R3: unknown code routes through bypass
        shift_ir(3'b111);
        tick(0, 0, 0, 0, 0, "");
        pat = 16'h002D;
        shift_dr(6, pat, {pat[14:0], 1'b0}, "R3 unknown code bypass");
        tick(0, 0, 0, 0, 0, "");
        check_val("R3 unknown code keeps update output", upd_out, 8'h81);

        // R1 / R7: reset via mode-select from Shift-IR after loading user code
        shift_ir(3'b010);
        tick(1, 0, 0, 0, 0, "");
        tick(1, 0, 0, 0, 0, "");
        tick(0, 0, 0, 0, 0, "");
        tick(0, 0, 0, 0, 0, "");
        for (int i = 0; i < 7; i++) tick(1, 1, 0, 0, 0, "");
        tick(0, 0, 1, 0, 0, "R1 in test-logic-reset");
        check_val("R7 reset state keeps update output", upd_out, 8'h81);
        pat = 16'h0005;
        shift_dr(4, pat, {pat[14:0], 1'b0}, "R7 bypass after reset state");
        tick(0, 0, 0, 0, 0, "");
        check_val("R7 update output after bypass", upd_out, 8'h81);

        // R10: reset pin in the middle of operation
        shift_ir(3'b010);
        tick(0, 0, 0, 0, 0, "");
        @(posedge tck);
        #2;
        trst = 1'b1;
        @(posedge tck);
        #2;
        trst = 1'b0;
        check_val("R10 reset pin clears update output", upd_out, 8'h00);
        tick(0, 0, 0, 0, 0, "");
        pat = 16'h0006;
        shift_dr(3, pat, {pat[14:0], 1'b0}, "R10 bypass after reset pin");

        repeat (3) @(posedge tck);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule